// File: doc/BRIEF.md
# Destination MAC Address Filter

This block decides, for each incoming frame, whether the frame should be handed to the host, by looking only at its 48-bit destination address. A lookup is requested by pulsing `addr_valid` with the address on `dst_addr`; one clock later the block presents a forward/drop decision, a flag saying whether the exact-match table produced a hit, and the index of the table entry that hit.

The decision combines three sources. The first is a table of exact addresses, each entry with its own enable and forward bits. The second is a set of class-wide controls that forward all unicast, all multicast or all broadcast frames; software uses these when the table is too small for the addresses it wants. The third is a promiscuous override. A host-forwarding master enable gates all three. Table entries and control bits are loaded through a simple write-only register port with byte addresses.

Address bytes are numbered in wire order. Byte 0 sits in `dst_addr[47:40]` and byte 5 in `dst_addr[7:0]`. A frame is multicast when bit 0 of byte 0 (`dst_addr[40]`) is 1. A frame is broadcast when all 48 bits are 1.

Top module: `dst_mac_filter`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after each cycle in which `addr_valid` is high, and low otherwise. While `dec_valid` is low, `dec_forward`, `dec_hit` and `dec_index` are all 0. Lookups on consecutive cycles each yield their own decision.
- R2: While bit 5 of the forwarding register (offset 0x010) is 0, every frame is dropped. This holds whatever the other control bits and the table contain.
- R3: With bit 7 (promiscuous) and bit 5 of the forwarding register both set, every frame is forwarded.
- R4: A broadcast address (all 48 bits 1) is forwarded when bit 5 of the class register (offset 0x014) is set. Broadcast is not covered by the multicast-all bit.
- R5: A multicast address that is not broadcast (`dst_addr[40]` = 1) is forwarded when bit 3 of the class register is set.
- R6: A unicast address (`dst_addr[40]` = 0) is forwarded when bit 1 of the class register is set.
- R7: Table entry n has two words. The low word at offset 0x100 + 8n holds address bytes 2..5, with byte 2 in bits 31:24 and byte 5 in bits 7:0. The high word at offset 0x104 + 8n holds byte 0 in bits 15:8, byte 1 in bits 7:0, the entry enable in bit 17 and the forward bit in bit 21. An exact match on an enabled entry that has its forward bit set forwards the frame, reports `dec_hit` = 1 and reports the entry index.
- R8: While bit 7 (table enable) of the class register is 0, no entry matches and `dec_hit` is 0.
- R9: When several enabled entries match, `dec_index` is the lowest matching index.
- R10: An enabled matching entry whose forward bit is 0 reports `dec_hit` = 1 with its index. It does not by itself forward the frame.
- R11: An entry whose enable bit is 0 never matches.
- R12: Writes to offsets that are not mapped leave all decisions unchanged. Mapped offsets are 0x010, 0x014 and the table words of entries 0..N_ENTRIES-1.
- R13: After reset all control bits and entries are 0. The first lookup is therefore dropped with no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Lookup request strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision present |
| dec_forward | output | 1 | 1 = forward to host, 0 = drop |
| dec_hit | output | 1 | An enabled table entry matched |
| dec_index | output | IDX_W | Lowest matching entry index |

## Verification
The bench builds the block with its default parameters: eight table entries and a 12-bit register offset. With these values every entry can be reached, including the last one at index 7 with its words at offsets 0x138/0x13C. The first offset past the table, 0x140, can also be written, which checks that the decoder does not alias out-of-range entries onto real ones. Eight entries also leave room to place duplicate addresses at non-adjacent indices, plus a disabled entry and an enabled non-forwarding entry, all at once. This lets the priority order and the per-entry bits be checked against each other in one table image.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    // Register byte offsets
    localparam int FWD_OFS    = 32'h010;
    localparam int CLS_OFS    = 32'h014;
    localparam int TBL_OFS    = 32'h100;
    localparam int TBL_STRIDE = 8;
    localparam int TBL_HI_OFS = 4;

    // Forwarding register bits
    localparam int HOST_EN_BIT = 5;
    localparam int PROMISC_BIT = 7;

    // Class register bits
    localparam int UC_ALL_BIT  = 1;
    localparam int MC_ALL_BIT  = 3;
    localparam int BC_FWD_BIT  = 5;
    localparam int TBL_EN_BIT  = 7;

    // Entry high word bits
    localparam int ENT_EN_BIT  = 17;
    localparam int ENT_FWD_BIT = 21;

    typedef struct packed {
        logic [47:0] mac;
        logic        en;
        logic        fwd;
    } entry_t;

    typedef struct packed {
        logic host_en;
        logic promisc;
        logic uc_all;
        logic mc_all;
        logic bc_fwd;
        logic tbl_en;
    } ctrl_t;

endpackage

// File: rtl/dmf_regs.sv
module dmf_regs
    import dmf_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int REG_AW    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    output entry_t [N_ENTRIES-1:0]     tbl,
    output ctrl_t                      ctrl
);

    typedef struct packed {
        entry_t [N_ENTRIES-1:0] tbl;
        ctrl_t                  ctrl;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr == REG_AW'(FWD_OFS)) begin
                s_d.ctrl.host_en = wr_data[HOST_EN_BIT];
                s_d.ctrl.promisc = wr_data[PROMISC_BIT];
            end
            if (wr_addr == REG_AW'(CLS_OFS)) begin
                s_d.ctrl.uc_all = wr_data[UC_ALL_BIT];
                s_d.ctrl.mc_all = wr_data[MC_ALL_BIT];
                s_d.ctrl.bc_fwd = wr_data[BC_FWD_BIT];
                s_d.ctrl.tbl_en = wr_data[TBL_EN_BIT];
            end
            for (int n = 0; n < N_ENTRIES; n++) begin
                if (wr_addr == REG_AW'(TBL_OFS + TBL_STRIDE * n)) begin
                    s_d.tbl[n].mac[31:0] = wr_data;
                end
                if (wr_addr == REG_AW'(TBL_OFS + TBL_STRIDE * n + TBL_HI_OFS)) begin
                    s_d.tbl[n].mac[47:32] = wr_data[15:0];
                    s_d.tbl[n].en         = wr_data[ENT_EN_BIT];
                    s_d.tbl[n].fwd        = wr_data[ENT_FWD_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tbl  = s_q.tbl;
    assign ctrl = s_q.ctrl;

    assert_cls_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AW'(CLS_OFS)) |=> (ctrl.tbl_en == $past(wr_data[TBL_EN_BIT])));

    assert_fwd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AW'(FWD_OFS)) |=> (ctrl.host_en == $past(wr_data[HOST_EN_BIT])));

endmodule

// File: rtl/dmf_match.sv
module dmf_match
    import dmf_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic [47:0]               addr,
    input  entry_t [N_ENTRIES-1:0]    tbl,
    input  logic                      tbl_en,
    output logic [N_ENTRIES-1:0]      hit_vec,
    output logic [N_ENTRIES-1:0]      fwd_vec
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = tbl_en & tbl[g].en & (tbl[g].mac == addr);
        assign fwd_vec[g] = hit_vec[g] & tbl[g].fwd;
    end

endmodule

// File: rtl/dmf_pick.sv
module dmf_pick #(
    parameter int N_REQ = 8,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req,
    output logic             any,
    output logic [IW-1:0]    idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dst_mac_filter.sv
module dst_mac_filter
    import dmf_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int REG_AW    = 12,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              addr_valid,
    input  logic [47:0]       dst_addr,
    output logic              dec_valid,
    output logic              dec_forward,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_index
);

    typedef struct packed {
        logic             valid;
        logic             forward;
        logic             hit;
        logic [IDX_W-1:0] index;
    } dec_t;

    entry_t [N_ENTRIES-1:0] tbl;
    ctrl_t                  ctrl;
    logic [N_ENTRIES-1:0]   hit_vec, fwd_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       hit_idx;
    logic                   is_bc, is_mc, is_uc, class_pass;
    dec_t                   dec_d, dec_q;

    dmf_regs #(.N_ENTRIES(N_ENTRIES), .REG_AW(REG_AW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .tbl     (tbl),
        .ctrl    (ctrl)
    );

    dmf_match #(.N_ENTRIES(N_ENTRIES)) i_match (
        .addr    (dst_addr),
        .tbl     (tbl),
        .tbl_en  (ctrl.tbl_en),
        .hit_vec (hit_vec),
        .fwd_vec (fwd_vec)
    );

    dmf_pick #(.N_REQ(N_ENTRIES)) i_pick (
        .req (hit_vec),
        .any (any_hit),
        .idx (hit_idx)
    );

    always_comb begin
        is_bc      = &dst_addr;
        is_mc      = dst_addr[40] & ~is_bc;
        is_uc      = ~dst_addr[40];
        class_pass = (is_bc & ctrl.bc_fwd) | (is_mc & ctrl.mc_all) | (is_uc & ctrl.uc_all);

        dec_d = '0;
        if (addr_valid) begin
            dec_d.valid   = 1'b1;
            dec_d.forward = ctrl.host_en & (ctrl.promisc | class_pass | (|fwd_vec));
            dec_d.hit     = any_hit;
            dec_d.index   = any_hit ? hit_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid   = dec_q.valid;
    assign dec_forward = dec_q.forward;
    assign dec_hit     = dec_q.hit;
    assign dec_index   = dec_q.index;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> dec_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !dec_valid);

    assert_quiet_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_forward && !dec_hit && dec_index == '0));

    assert_host_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ctrl.host_en) |=> !dec_forward);

    assert_promisc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ctrl.host_en && ctrl.promisc) |=> dec_forward);

    assert_table_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ctrl.tbl_en) |=> !dec_hit);

    assert_lowest_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && hit_vec[0]) |=> (dec_hit && dec_index == '0));

endmodule

// File: tb/test_dst_mac_filter.sv
module test_dst_mac_filter;

    localparam int N  = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          addr_valid = 1'b0;
    logic [47:0]   dst_addr = '0;
    logic          dec_valid, dec_forward, dec_hit;
    logic [2:0]    dec_index;

    always #2.5 clk = ~clk;

    dst_mac_filter #(.N_ENTRIES(N), .REG_AW(AW)) i_dst_mac_filter (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .addr_valid (addr_valid), .dst_addr (dst_addr),
        .dec_valid (dec_valid), .dec_forward (dec_forward),
        .dec_hit (dec_hit), .dec_index (dec_index)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Shadow of the programmed state, decoded from the requirement text
    logic [47:0] sh_mac [N];
    logic        sh_en  [N];
    logic        sh_fwd [N];
    logic sh_host = 0, sh_prom = 0, sh_uc = 0, sh_mc = 0, sh_bc = 0, sh_tbl = 0;

    typedef struct packed {
        logic       f;
        logic       h;
        logic [2:0] i;
        int         stamp;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    function automatic exp_t predict(logic [47:0] a);
        exp_t e;
        logic bc, mc, uc, tfwd, pass;
        e = '0;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        mc = a[40] && !bc;
        uc = !a[40];
        tfwd = 1'b0;
        if (sh_tbl) begin
            for (int k = 0; k < N; k++) begin
                if (sh_en[k] && sh_mac[k] == a) begin
                    if (!e.h) begin
                        e.h = 1'b1;
                        e.i = 3'(k);
                    end
                    if (sh_fwd[k]) tfwd = 1'b1;
                end
            end
        end
        pass = sh_prom || (bc && sh_bc) || (mc && sh_mc) || (uc && sh_uc) || tfwd;
        e.f = sh_host && pass;
        return e;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_valid = 1'b0;
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        if (a == 12'h010) begin
            sh_host = d[5];
            sh_prom = d[7];
        end
        if (a == 12'h014) begin
            sh_uc  = d[1];
            sh_mc  = d[3];
            sh_bc  = d[5];
            sh_tbl = d[7];
        end
        for (int k = 0; k < N; k++) begin
            if (a == 12'(12'h100 + 8 * k)) sh_mac[k][31:0] = d;
            if (a == 12'(12'h104 + 8 * k)) begin
                sh_mac[k][47:32] = d[15:0];
                sh_en[k]  = d[17];
                sh_fwd[k] = d[21];
            end
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr_entry(input int n, input logic [47:0] mac, input logic en, input logic fwd);
        logic [31:0] hi;
        hi = {10'd0, fwd, 3'd0, en, 1'b0, mac[47:32]};
        wr(12'(12'h100 + 8 * n), mac[31:0]);
        wr(12'(12'h104 + 8 * n), hi);
    endtask

    // Driver: leaves addr_valid high so consecutive calls are back-to-back
    task automatic lookup(input logic [47:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        e = predict(a);
        e.stamp = cyc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr_valid = 1'b1;
        dst_addr   = a;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        addr_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].stamp + 1 == cyc) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (!dec_valid || dec_forward !== e.f || dec_hit !== e.h ||
                    (e.h && dec_index !== e.i)) begin
                    failures++;
                    $display("FAIL %s: got v=%0b f=%0b h=%0b i=%0d, expected v=1 f=%0b h=%0b i=%0d",
                             t, dec_valid, dec_forward, dec_hit, dec_index, e.f, e.h, e.i);
                end
            end else if (dec_valid) begin
                checks++;
                failures++;
                $display("FAIL R1: got dec_valid=1 with no lookup pending, expected 0");
            end
        end
    end

    localparam logic [47:0] UC_X = 48'h0012_3456_789A;
    localparam logic [47:0] MC_X = 48'h0100_5E00_0001;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] A    = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] B    = 48'h3333_0000_00FB;
    localparam logic [47:0] C    = 48'h0200_0000_0042;
    localparam logic [47:0] D    = 48'h0600_1111_2222;
    localparam logic [47:0] E    = 48'h0155_6677_8899;
    localparam logic [47:0] F    = 48'h0E00_DEAD_BEEF;

    initial begin
        for (int k = 0; k < N; k++) begin
            sh_mac[k] = '0;
            sh_en[k]  = 1'b0;
            sh_fwd[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0 || dec_forward !== 1'b0 || dec_hit !== 1'b0) begin
            failures++;
            $display("FAIL R13: got v=%0b f=%0b h=%0b after reset, expected 0 0 0",
                     dec_valid, dec_forward, dec_hit);
        end
        lookup(UC_X, "R13");
        lookup(48'h0, "R13");
        idle(2);

        // Class bits set but host forwarding disabled
        wr(12'h014, 32'h0000_00AA);
        wr_entry(1, UC_X, 1'b1, 1'b1);
        lookup(UC_X, "R2");
        lookup(MC_X, "R2");
        lookup(BC, "R2");
        idle(2);
        wr_entry(1, 48'h0, 1'b0, 1'b0);

        // All classes on
        wr(12'h014, 32'h0000_002A);
        wr(12'h010, 32'h0000_0020);
        lookup(UC_X, "R6");
        lookup(MC_X, "R5");
        lookup(BC, "R4");
        idle(2);

        // Multicast-all only
        wr(12'h014, 32'h0000_0008);
        lookup(BC, "R4");
        lookup(UC_X, "R6");
        lookup(MC_X, "R5");
        idle(2);

        // Broadcast only
        wr(12'h014, 32'h0000_0020);
        lookup(BC, "R4");
        lookup(MC_X, "R5");
        idle(2);

        // Unicast only
        wr(12'h014, 32'h0000_0002);
        lookup(UC_X, "R6");
        lookup(MC_X, "R6");
        idle(2);

        // Promiscuous
        wr(12'h014, 32'h0000_0000);
        wr(12'h010, 32'h0000_00A0);
        lookup(UC_X, "R3");
        lookup(MC_X, "R3");
        lookup(F, "R3");
        idle(2);
        wr(12'h010, 32'h0000_0080);
        lookup(UC_X, "R2");
        idle(2);

        // Exact-match table
        wr(12'h010, 32'h0000_0020);
        wr(12'h014, 32'h0000_0080);
        wr_entry(0, A, 1'b1, 1'b1);
        wr_entry(3, B, 1'b1, 1'b1);
        wr_entry(5, B, 1'b1, 1'b1);
        wr_entry(6, C, 1'b1, 1'b0);
        wr_entry(4, D, 1'b0, 1'b1);
        wr_entry(7, E, 1'b1, 1'b1);
        lookup(A, "R7");
        lookup(E, "R7");
        lookup(A ^ 48'h1, "R7");
        lookup(A ^ 48'h0100_0000_0000, "R7");
        lookup(B, "R9");
        lookup(C, "R10");
        lookup(D, "R11");
        lookup(F, "R7");
        idle(2);

        // Table disabled
        wr(12'h014, 32'h0000_0000);
        lookup(A, "R8");
        lookup(B, "R8");
        idle(2);

        // Unmapped writes
        wr(12'h014, 32'h0000_0080);
        wr(12'h140, F[31:0]);
        wr(12'h144, {10'd0, 1'b1, 3'd0, 1'b1, 1'b0, F[47:32]});
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h0FC, 32'hFFFF_FFFF);
        lookup(F, "R12");
        lookup(UC_X, "R12");
        lookup(A, "R12");
        idle(2);

        // Disable entry 3: next duplicate takes over
        wr_entry(3, B, 1'b0, 1'b1);
        lookup(B, "R9");
        lookup(C, "R10");
        idle(1);

        // Back-to-back lookups
        lookup(A, "R1");
        lookup(C, "R1");
        lookup(E, "R1");
        lookup(D, "R1");
        idle(3);

        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R1: got %0d decisions missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1: got watchdog expiry, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule